// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock waveform for an I2C master from a fast functional clock. A programmable prescaler divides the functional clock into an internal time base. Two 8-bit counts then set the length of the low and high halves of each SCL period. A fixed offset is added to each count: seven internal periods for the low half and five for the high half. The bit period is therefore (prescale+1)·(low+7+high+5) functional clocks, not a plain divide-by-N.

A bit sequencer starts the clock with a run request. It receives a one-clock strobe at every falling and every rising SCL edge. During the high half, the sampled bus line is watched. While a target holds the line low, the count is frozen, which supports clock stretching. The timing registers are 16 bits wide. Only the low byte of each sets the timing. The upper bytes hold the high-speed low/high counts, which are captured and presented unchanged. All configuration is captured at the start of each period, so a change takes effect only from the next period.

Top module: `sclTimingGen`

## Requirements
- R1: While `enable` is low, `sclDrive` is 1 and both strobes are 0 from the next clock on, and all counters are cleared. After re-enabling, the first low half has its full length.
- R2: With `enable` high and the generator idle, a high `run` drives `sclDrive` to 0 at the next clock edge, and `fallTick` is 1 for exactly that first low cycle.
- R3: The low half lasts (prescale+1)·(lowCfg[7:0]+7) functional clocks.
- R4: The high half lasts (prescale+1)·(highCfg[7:0]+5) functional clocks when the line is not held low.
- R5: `riseTick` is 1 for exactly the first cycle of each high half, and only then.
- R6: `run` is examined only when a high half ends. If it is 1, a new period starts at once with `fallTick`. If it is 0, the generator goes idle with `sclDrive` held at 1 and no strobe.
- R7: During a high half, except in its first cycle, every clock edge at which the registered sample of `sclIn` is 0 freezes all counting. The high half is lengthened by exactly the number of such edges.
- R8: Bits [15:8] of `lowCfg` and `highCfg` have no effect on timing. After a period starts, `hsTiming` shows {highCfg[15:8], lowCfg[15:8]} as captured at that start.
- R9: `prescale`, `lowCfg` and `highCfg` are captured only at the edge that starts a period. A change in mid-period leaves the current period unaltered.
- R10: After reset, `sclDrive` is 1, both strobes are 0 and `hsTiming` is 0.
- R11: With prescale 1, the low/high pairs 111/117, 23/25 and 5/7 give periods of 480, 120 and 48 functional clocks. At a 48 MHz functional clock these are 100 kHz, 400 kHz and 1 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low releases SCL and clears counters |
| run | input | 1 | Request to keep generating SCL periods |
| prescale | input | PSC_W | Prescale value; internal time base is clk/(prescale+1) |
| lowCfg | input | 2·CNT_W | [7:0] low count, [15:8] high-speed low count (stored only) |
| highCfg | input | 2·CNT_W | [7:0] high count, [15:8] high-speed high count (stored only) |
| sclIn | input | 1 | Sampled level of the SCL bus line |
| sclDrive | output | 1 | SCL drive: 0 pulls low, 1 releases |
| riseTick | output | 1 | One-clock strobe at the start of each high half |
| fallTick | output | 1 | One-clock strobe at the start of each low half |
| hsTiming | output | 2·CNT_W | Captured {high-speed high, high-speed low} counts |

## Verification
The generator is run with a zero prescale and small counts, which exposes off-by-one errors in the fixed offsets. A prescale of 2 with nonzero upper bytes separates a prescale fault from a counter fault and shows whether the high-speed bytes leak into timing. The three standard rate settings confirm the full period formula. A mid-period configuration change distinguishes capture at period start from live use of the inputs. A target hold in the middle of a high half, and a disable in the middle of a low half, test the freeze and clear paths. Dropping `run` shows that a period always finishes before the generator goes idle.

// File: rtl/sclTimingPkg.sv
package sclTimingPkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero prescaler and phase counter
    logic capture;  // load configuration shadows
    logic count;    // advance counters this cycle
    logic selHigh;  // compare against the high-half limit
  } pathCtl_t;

endpackage

// File: rtl/sclTimingPath.sv
module sclTimingPath
  import sclTimingPkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathCtl_t             ctl,
  input  logic [PSC_W-1:0]     prescale,
  input  logic [2*CNT_W-1:0]   lowCfg,
  input  logic [2*CNT_W-1:0]   highCfg,
  output logic                 phaseDone,
  output logic [2*CNT_W-1:0]   hsTiming
);

  localparam int PH_W = CNT_W + 1;

  logic [PSC_W-1:0] shPsc;
  logic [CNT_W-1:0] shLow, shHigh, shHsLow, shHsHigh;
  logic [PSC_W-1:0] pCnt;
  logic [PH_W-1:0]  phCnt;
  logic [PH_W-1:0]  limit;
  logic             pWrap;

  // phase length in internal ticks, fixed offsets per half
  assign limit = ctl.selHigh ? ({1'b0, shHigh} + PH_W'(HIGH_OFS))
                             : ({1'b0, shLow}  + PH_W'(LOW_OFS));

  assign pWrap     = (pCnt == shPsc);
  assign phaseDone = pWrap && (phCnt == limit - PH_W'(1));
  assign hsTiming  = {shHsHigh, shHsLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPsc    <= '0;
      shLow    <= '0;
      shHigh   <= '0;
      shHsLow  <= '0;
      shHsHigh <= '0;
    end else if (ctl.capture) begin
      shPsc    <= prescale;
      shLow    <= lowCfg[CNT_W-1:0];
      shHigh   <= highCfg[CNT_W-1:0];
      shHsLow  <= lowCfg[2*CNT_W-1:CNT_W];
      shHsHigh <= highCfg[2*CNT_W-1:CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pCnt  <= '0;
      phCnt <= '0;
    end else if (ctl.clear) begin
      pCnt  <= '0;
      phCnt <= '0;
    end else if (ctl.count) begin
      if (pWrap) begin
        pCnt  <= '0;
        phCnt <= phCnt + PH_W'(1);
      end else begin
        pCnt <= pCnt + PSC_W'(1);
      end
    end
  end

  // R3
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pCnt <= shPsc);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phCnt < limit);

  // R7
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.count && !ctl.clear) |=> ($stable(pCnt) && $stable(phCnt)));

endmodule

// File: rtl/sclTimingCtrl.sv
module sclTimingCtrl
  import sclTimingPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     run,
  input  logic     sclIn,
  input  logic     phaseDone,
  output pathCtl_t ctl,
  output logic     sclDrive,
  output logic     riseTick,
  output logic     fallTick
);

  phase_e state, stateNxt;
  logic   sclQ;
  logic   frozen, advance, active;
  logic   sclNxt, riseNxt, fallNxt;

  assign active  = (state != PH_IDLE);
  // first high cycle is masked: the sample still shows our own low drive
  assign frozen  = (state == PH_HIGH) && !riseTick && !sclQ;
  assign advance = ctl.count && phaseDone;

  always_comb begin
    ctl.count   = enable && active && !frozen;
    ctl.selHigh = (state == PH_HIGH);
    ctl.clear   = !enable || (state == PH_IDLE) || (ctl.count && phaseDone);
    ctl.capture = enable && run &&
                  ((state == PH_IDLE) || ((state == PH_HIGH) && ctl.count && phaseDone));
  end

  always_comb begin
    stateNxt = state;
    sclNxt   = sclDrive;
    riseNxt  = 1'b0;
    fallNxt  = 1'b0;
    if (!enable) begin
      stateNxt = PH_IDLE;
      sclNxt   = 1'b1;
    end else begin
      unique case (state)
        PH_IDLE: if (run) begin
          stateNxt = PH_LOW;
          sclNxt   = 1'b0;
          fallNxt  = 1'b1;
        end
        PH_LOW: if (advance) begin
          stateNxt = PH_HIGH;
          sclNxt   = 1'b1;
          riseNxt  = 1'b1;
        end
        PH_HIGH: if (advance) begin
          if (run) begin
            stateNxt = PH_LOW;
            sclNxt   = 1'b0;
            fallNxt  = 1'b1;
          end else begin
            stateNxt = PH_IDLE;
            sclNxt   = 1'b1;
          end
        end
        default: begin
          stateNxt = PH_IDLE;
          sclNxt   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      sclDrive <= 1'b1;
      riseTick <= 1'b0;
      fallTick <= 1'b0;
      sclQ     <= 1'b1;
    end else begin
      state    <= stateNxt;
      sclDrive <= sclNxt;
      riseTick <= riseNxt;
      fallTick <= fallNxt;
      sclQ     <= sclIn;
    end
  end

  // R2
  fall_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallTick |-> !sclDrive);

  // R5
  rise_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseTick |-> sclDrive);

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclDrive && !riseTick && !fallTick));

  // R5
  rise_edge_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclDrive) && $past(enable)) |-> riseTick);

  // R2
  fall_edge_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDrive) |-> fallTick);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == PH_IDLE) && !run) |=> (sclDrive && !fallTick && !riseTick));

endmodule

// File: rtl/sclTimingGen.sv
module sclTimingGen
  import sclTimingPkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int CNT_W    = 8,
  parameter int LOW_OFS  = 7,
  parameter int HIGH_OFS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 run,
  input  logic [PSC_W-1:0]     prescale,
  input  logic [2*CNT_W-1:0]   lowCfg,
  input  logic [2*CNT_W-1:0]   highCfg,
  input  logic                 sclIn,
  output logic                 sclDrive,
  output logic                 riseTick,
  output logic                 fallTick,
  output logic [2*CNT_W-1:0]   hsTiming
);

  pathCtl_t ctl;
  logic     phaseDone;

  sclTimingCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .run       (run),
    .sclIn     (sclIn),
    .phaseDone (phaseDone),
    .ctl       (ctl),
    .sclDrive  (sclDrive),
    .riseTick  (riseTick),
    .fallTick  (fallTick)
  );

  sclTimingPath #(
    .PSC_W    (PSC_W),
    .CNT_W    (CNT_W),
    .LOW_OFS  (LOW_OFS),
    .HIGH_OFS (HIGH_OFS)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .prescale  (prescale),
    .lowCfg    (lowCfg),
    .highCfg   (highCfg),
    .phaseDone (phaseDone),
    .hsTiming  (hsTiming)
  );

endmodule

// File: tb/tb_sclTimingGen.sv
module tb_sclTimingGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  prescale = '0;
  logic [15:0] lowCfg = '0;
  logic [15:0] highCfg = '0;
  logic        holdLow = 1'b0;
  logic        sclIn;
  logic        sclDrive, riseTick, fallTick;
  logic [15:0] hsTiming;

  int checks = 0;
  int errors = 0;
  string curReq = "R10";
  bit cmpOn = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign sclIn = sclDrive & ~holdLow;

  sclTimingGen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .run(run),
    .prescale(prescale), .lowCfg(lowCfg), .highCfg(highCfg),
    .sclIn(sclIn), .sclDrive(sclDrive), .riseTick(riseTick),
    .fallTick(fallTick), .hsTiming(hsTiming)
  );

  // behavioural reference: remaining functional clocks in the current half
  int mPh = 0;       // 0 idle, 1 low, 2 high
  int mLeft = 0;
  int mPsc = 0, mL = 0, mH = 0;
  bit mScl = 1'b1, mRise = 1'b0, mFall = 1'b0, mSclQ = 1'b1;
  logic [15:0] mHs = '0;

  task automatic startLow();
    mPsc  = int'(prescale);
    mL    = int'(lowCfg[7:0]);
    mH    = int'(highCfg[7:0]);
    mHs   = {highCfg[15:8], lowCfg[15:8]};
    mPh   = 1;
    mScl  = 1'b0;
    mFall = 1'b1;
    mLeft = (mPsc + 1) * (mL + 7);
  endtask

  always @(posedge clk) begin
    bit prevRise;
    if (!rstN) begin
      mPh = 0; mLeft = 0; mScl = 1'b1; mRise = 1'b0; mFall = 1'b0;
      mHs = '0; mSclQ = 1'b1;
    end else begin
      prevRise = mRise;
      mRise = 1'b0;
      mFall = 1'b0;
      if (!enable) begin
        mPh = 0; mScl = 1'b1;
      end else begin
        case (mPh)
          0: if (run) startLow();
          1: begin
            mLeft--;
            if (mLeft == 0) begin
              mPh = 2; mScl = 1'b1; mRise = 1'b1;
              mLeft = (mPsc + 1) * (mH + 5);
            end
          end
          default: if (prevRise || mSclQ) begin
            mLeft--;
            if (mLeft == 0) begin
              if (run) startLow();
              else begin mPh = 0; mScl = 1'b1; end
            end
          end
        endcase
      end
      mSclQ = sclIn;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if ({sclDrive, riseTick, fallTick, hsTiming} !== {mScl, mRise, mFall, mHs}) begin
        errors++;
        $display("FAIL %s cycle compare: got scl=%0b rise=%0b fall=%0b hs=%h exp scl=%0b rise=%0b fall=%0b hs=%h",
                 curReq, sclDrive, riseTick, fallTick, hsTiming, mScl, mRise, mFall, mHs);
      end
    end
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic waitFall();
    do @(negedge clk); while (!fallTick);
  endtask

  task automatic measurePeriod(output int n);
    waitFall();
    n = 0;
    do begin @(negedge clk); n++; end while (!fallTick);
  endtask

  task automatic setCfg(int psc, logic [15:0] lo, logic [15:0] hi);
    prescale = 8'(psc);
    lowCfg   = lo;
    highCfg  = hi;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit sawTick;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", int'(sclDrive), 1);
    check("R10", int'(riseTick | fallTick), 0);
    check("R10", int'(hsTiming), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;

    // R1 disabled: run has no effect
    curReq = "R1";
    run = 1'b1;
    setCfg(0, 16'h0002, 16'h0001);
    repeat (20) @(negedge clk);
    check("R1", int'(sclDrive), 1);

    // R2 R3 R4 R5 smallest prescale
    curReq = "R3";
    enable = 1'b1;
    @(negedge clk);
    check("R2", int'(fallTick), 1);
    check("R2", int'(sclDrive), 0);
    n = 1;
    while (!riseTick) begin @(negedge clk); if (!riseTick) n++; end
    check("R3", n, 9);  // 1*(2+7)
    n = 1;
    do begin @(negedge clk); if (!fallTick) n++; end while (!fallTick);
    check("R4", n, 6);  // 1*(1+5)
    curReq = "R5";
    repeat (3) begin measurePeriod(n); check("R5", n, 15); end

    // R8 upper bytes stored only; prescale 2
    curReq = "R8";
    setCfg(2, 16'hA500, 16'h3C03);
    waitFall();
    measurePeriod(n);
    check("R8", n, 45);  // 3*7 + 3*8
    check("R8", int'(hsTiming), 16'h3CA5);

    // R9 mid-period change waits for the next period
    curReq = "R9";
    waitFall();
    setCfg(0, 16'h0001, 16'h0001);
    n = 0;
    do begin @(negedge clk); n++; end while (!fallTick);
    check("R9", n, 45);
    measurePeriod(n);
    check("R9", n, 14);

    // R11 standard rates at prescale 1
    curReq = "R11";
    setCfg(1, 16'd111, 16'd117);
    waitFall(); measurePeriod(n); check("R11", n, 480);
    setCfg(1, 16'd23, 16'd25);
    waitFall(); measurePeriod(n); check("R11", n, 120);
    setCfg(1, 16'd5, 16'd7);
    waitFall(); measurePeriod(n); check("R11", n, 48);

    // R7 target holds the line for 10 cycles mid high half
    curReq = "R7";
    do @(negedge clk); while (!riseTick);
    n = 1;
    do begin
      @(negedge clk);
      if (n == 4) holdLow = 1'b1;
      if (n == 14) holdLow = 1'b0;
      if (!fallTick) n++;
    end while (!fallTick);
    holdLow = 1'b0;
    check("R7", n, 34);  // 24 + 10

    // R1 disable mid-low, then full first low after re-enable
    curReq = "R1";
    waitFall();
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R1", int'(sclDrive), 1);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R1", int'(fallTick), 1);
    n = 1;
    while (!riseTick) begin @(negedge clk); if (!riseTick) n++; end
    check("R1", n, 24);

    // R6 drop run mid-period: finish, then idle high
    curReq = "R6";
    repeat (5) @(negedge clk);
    run = 1'b0;
    repeat (60) @(negedge clk);
    sawTick = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (fallTick || riseTick || !sclDrive) sawTick = 1'b1;
    end
    check("R6", int'(sawTick), 0);
    run = 1'b1;
    @(negedge clk);
    check("R6", int'(fallTick), 1);
    repeat (10) @(negedge clk);

    cmpOn = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule